// File: doc/BRIEF.md
# Matched Complementary Pulse Generator

This block drives the low-side switch of a half-bridge with a pulse whose width copies the high-side pulse that came just before it. The high-side pulse has a variable width because an external comparator decides when it ends. That means the low-side on-time cannot be programmed ahead of time. Instead, the block measures it on the fly. An up/down counter climbs while the high-side input is high. After the high-side input falls, the counter descends at the same rate, and the raw low-side pulse stays asserted until the count is used up.

The final low-side output is the raw pulse with a programmable turn-on delay (dead time), measured in clock cycles. The delay applies only to the leading edge, so the final output falls in the same cycle as the raw pulse. When the low-side pulse ends, the block emits a one-cycle synchronization strobe that can re-align the high-side timer. If a new high-side pulse starts while the low-side pulse is still active, the low-side pulse is cut short at once and a fresh measurement begins from zero.

Top module: `matched_pulse_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `ls_out`, `ls_raw` and `sync_pulse` are 0 after that edge and the stored width is cleared. After reset is released with `hs_in` low, no low-side pulse appears.
- R2: `ls_raw` goes to 1 at the first clock edge at which `hs_in` is sampled 0 after having been sampled 1 at the previous edge.
- R3: Let the high-side pulse be sampled 1 at N consecutive edges. Then `ls_raw` stays 1 for exactly N consecutive cycles.
- R4: Let `dead_cycles` be D with D < N. Then `ls_out` rises D cycles after `ls_raw` rises, and it falls at the same edge as `ls_raw`, so it is high for N-D cycles.
- R5: If D >= N, `ls_out` stays 0 for the whole low-side pulse.
- R6: `sync_pulse` is high for exactly one cycle. That cycle is the first cycle in which `ls_raw` is 0 after having been 1.
- R7: Suppose `hs_in` is sampled rising while `ls_raw` is 1. Then at that edge `ls_raw` and `ls_out` go to 0 and `sync_pulse` goes to 1. The next low-side pulse has the width of the new high-side pulse alone.
- R8: The width counter never decrements below zero. With `hs_in` held low after a completed pulse, `ls_raw` and `sync_pulse` stay 0.
- R9: `ls_out` is never 1 while `ls_raw` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_in | input | 1 | High-side gate pulse whose width is measured |
| dead_cycles | input | DT_W | Leading-edge delay of the low-side output, in clock cycles |
| ls_out | output | 1 | Final low-side gate output, with dead time applied |
| ls_raw | output | 1 | Low-side pulse before dead time, same width as the high-side pulse |
| sync_pulse | output | 1 | One-cycle strobe marking the end of the low-side pulse |

## Verification
The hardest situation to reach is a new high-side edge arriving in the middle of a replay. The counter then holds a partly spent count, which must be discarded rather than added to the new measurement. The bench gets there by counting cycles after the low-side pulse starts and raising `hs_in` at a known offset inside it. It then checks the immediate cut-off and the width of the next replayed pulse. A second hard case is a dead time equal to or longer than the pulse. It is reached by table entries where D >= N, and those entries must leave `ls_out` silent.

// File: rtl/mpg_pkg.sv
package mpg_pkg;
  typedef enum logic {
    LS_OFF = 1'b0,
    LS_ON  = 1'b1
  } ls_state_t;
endpackage

// File: rtl/mpg_edge.sv
module mpg_edge (
  input  logic clk,
  input  logic rst,
  input  logic sig_in,
  output logic rise,
  output logic fall
);
  logic sig_q;

  always_ff @(posedge clk) begin
    if (rst) sig_q <= 1'b0;
    else     sig_q <= sig_in;
  end

  assign rise = sig_in & ~sig_q;
  assign fall = ~sig_in & sig_q;
endmodule

// File: rtl/mpg_updown.sv
module mpg_updown #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hs_in,
  input  logic             restart,
  output logic [CNT_W-1:0] count,
  output logic             at_zero
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst)                count <= '0;
    else if (restart)       count <= CNT_ONE;
    else if (hs_in) begin
      if (count != CNT_MAX) count <= count + CNT_ONE;
    end
    else if (count != '0)   count <= count - CNT_ONE;
  end

  assign at_zero = (count == '0);

  // Floor at zero: an idle low input keeps an empty counter empty.
  assert_floor_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (at_zero && !hs_in) |=> at_zero);
endmodule

// File: rtl/mpg_replay_fsm.sv
module mpg_replay_fsm
  import mpg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hs_in,
  input  logic hs_rise,
  input  logic hs_fall,
  input  logic cnt_zero,
  output logic raw_q,
  output logic raw_nxt,
  output logic sync_q
);
  ls_state_t state_q, state_d;
  logic      end_now;

  always_comb begin
    state_d = state_q;
    end_now = 1'b0;
    case (state_q)
      LS_OFF: if (hs_fall) state_d = LS_ON;
      LS_ON: begin
        if (hs_rise || cnt_zero) begin
          state_d = LS_OFF;
          end_now = 1'b1;
        end
      end
      default: state_d = LS_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= LS_OFF;
      sync_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sync_q  <= end_now;
    end
  end

  assign raw_q   = (state_q == LS_ON);
  assign raw_nxt = (state_d == LS_ON);

  assert_raw_on_fall_R2: assert property (@(posedge clk) disable iff (rst)
    ($fell(hs_in) && !$past(rst)) |=> raw_q);
  assert_sync_single_R6: assert property (@(posedge clk) disable iff (rst)
    sync_q |=> !sync_q);
  assert_sync_at_end_R6: assert property (@(posedge clk) disable iff (rst)
    sync_q |-> (!raw_q && $past(raw_q)));
  assert_abort_on_rise_R7: assert property (@(posedge clk) disable iff (rst)
    ($rose(hs_in) && raw_q && !$past(rst)) |=> (!raw_q && sync_q));
endmodule

// File: rtl/mpg_dead_gate.sv
module mpg_dead_gate #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            raw_q,
  input  logic            raw_nxt,
  input  logic [DT_W-1:0] dead_cycles,
  output logic            gated_q
);
  localparam int AGE_W = DT_W + 1;
  localparam logic [AGE_W-1:0] AGE_MAX = '1;
  localparam logic [AGE_W-1:0] AGE_ONE = AGE_W'(1);

  logic [AGE_W-1:0] age_q, age_d;
  logic             gated_d;

  always_comb begin
    if (!raw_nxt)          age_d = '0;
    else if (!raw_q)       age_d = AGE_ONE;
    else if (age_q != AGE_MAX) age_d = age_q + AGE_ONE;
    else                   age_d = age_q;
    gated_d = raw_nxt && (age_d > {1'b0, dead_cycles});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      age_q   <= '0;
      gated_q <= 1'b0;
    end else begin
      age_q   <= age_d;
      gated_q <= gated_d;
    end
  end

  assert_fall_together_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(raw_q) |-> !gated_q);
endmodule

// File: rtl/matched_pulse_gen.sv
module matched_pulse_gen #(
  parameter int CNT_W = 32,
  parameter int DT_W  = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hs_in,
  input  logic [DT_W-1:0] dead_cycles,
  output logic            ls_out,
  output logic            ls_raw,
  output logic            sync_pulse
);
  logic             hs_rise, hs_fall;
  logic [CNT_W-1:0] width_cnt;
  logic             cnt_zero;
  logic             raw_q, raw_nxt, sync_q, gated_q;

  mpg_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .sig_in (hs_in),
    .rise   (hs_rise),
    .fall   (hs_fall)
  );

  mpg_updown #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .hs_in   (hs_in),
    .restart (hs_rise),
    .count   (width_cnt),
    .at_zero (cnt_zero)
  );

  mpg_replay_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .hs_in    (hs_in),
    .hs_rise  (hs_rise),
    .hs_fall  (hs_fall),
    .cnt_zero (cnt_zero),
    .raw_q    (raw_q),
    .raw_nxt  (raw_nxt),
    .sync_q   (sync_q)
  );

  mpg_dead_gate #(.DT_W(DT_W)) u_gate (
    .clk         (clk),
    .rst         (rst),
    .raw_q       (raw_q),
    .raw_nxt     (raw_nxt),
    .dead_cycles (dead_cycles),
    .gated_q     (gated_q)
  );

  assign ls_out     = gated_q;
  assign ls_raw     = raw_q;
  assign sync_pulse = sync_q;

  assert_out_within_raw_R9: assert property (@(posedge clk) disable iff (rst)
    ls_out |-> ls_raw);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!ls_out && !ls_raw && !sync_pulse));
  assert_no_sync_while_on_R6: assert property (@(posedge clk) disable iff (rst)
    sync_pulse |-> !ls_out);
endmodule

// File: tb/matched_pulse_gen_bench.sv
`timescale 1ns/1ps
module matched_pulse_gen_bench;
  localparam int DT_W = 8;
  localparam int NVEC = 8;
  // {high-side width N, dead time D}
  localparam logic [15:0] VEC [NVEC] = '{
    {8'd5,  8'd2}, {8'd1,  8'd0}, {8'd3,  8'd3}, {8'd10, 8'd0},
    {8'd7,  8'd6}, {8'd2,  8'd5}, {8'd20, 8'd4}, {8'd4,  8'd1}
  };

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            hs_in = 1'b0;
  logic [DT_W-1:0] dead_cycles = '0;
  logic            ls_out, ls_raw, sync_pulse;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  matched_pulse_gen #(.CNT_W(32), .DT_W(DT_W)) u_matched_pulse_gen (
    .clk         (clk),
    .rst         (rst),
    .hs_in       (hs_in),
    .dead_cycles (dead_cycles),
    .ls_out      (ls_out),
    .ls_raw      (ls_raw),
    .sync_pulse  (sync_pulse)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hs_high(input int n);
    @(negedge clk) hs_in = 1'b1;
    repeat (n) @(negedge clk);
    hs_in = 1'b0;
  endtask

  // hs_in was just driven low at a negedge; observe the replay window.
  task automatic measure(input int n, input int d);
    int raw_cnt = 0, out_cnt = 0, sync_cnt = 0;
    int raw_first = -1, raw_last = -1, out_first = -1, sync_idx = -1;
    int exp_out;
    for (int i = 0; i < n + d + 8; i++) begin
      @(posedge clk); #1;
      if (ls_raw) begin
        raw_cnt++;
        if (raw_first < 0) raw_first = i;
        raw_last = i;
      end
      if (ls_out) begin
        out_cnt++;
        if (out_first < 0) out_first = i;
      end
      if (sync_pulse) begin
        sync_cnt++;
        if (sync_idx < 0) sync_idx = i;
      end
    end
    exp_out = (n > d) ? n - d : 0;
    chk(raw_first == 0, "R2 raw start", raw_first, 0);
    chk(raw_cnt == n && raw_last == n - 1, "R3 raw width", raw_cnt, n);
    if (n > d) begin
      chk(out_cnt == exp_out, "R4 out width", out_cnt, exp_out);
      chk(out_first == d, "R4 out delay", out_first, d);
    end else begin
      chk(out_cnt == 0, "R5 out suppressed", out_cnt, 0);
    end
    chk(sync_cnt == 1 && sync_idx == n, "R6 sync position", sync_idx, n);
  endtask

  initial begin
    #2_000_000;
    chk(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!ls_out && !ls_raw && !sync_pulse, "R1 reset outputs", {ls_out, ls_raw, sync_pulse}, 0);
    @(negedge clk) rst = 1'b0;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      dead_cycles = VEC[v][7:0];
      hs_high(int'(VEC[v][15:8]));
      measure(int'(VEC[v][15:8]), int'(VEC[v][7:0]));
      @(negedge clk);
    end

    // R8: long idle after a pulse, no activity
    begin
      int act = 0;
      for (int i = 0; i < 40; i++) begin
        @(posedge clk); #1;
        if (ls_raw || sync_pulse || ls_out) act++;
      end
      chk(act == 0, "R8 idle floor", act, 0);
    end

    // R7: new rising edge in the middle of a replay
    dead_cycles = 8'd0;
    hs_high(10);
    repeat (3) @(posedge clk);
    @(negedge clk) hs_in = 1'b1;
    @(posedge clk); #1;
    chk(!ls_raw && !ls_out, "R7 abort raw low", ls_raw, 0);
    chk(sync_pulse, "R7 abort sync", sync_pulse, 1);
    repeat (4) @(negedge clk);
    hs_in = 1'b0;
    measure(4, 0);
    @(negedge clk);

    // R1: reset in the middle of a replay
    dead_cycles = 8'd1;
    hs_high(6);
    repeat (2) @(posedge clk);
    @(negedge clk) rst = 1'b1;
    @(posedge clk); #1;
    chk(!ls_out && !ls_raw && !sync_pulse, "R1 mid reset", {ls_out, ls_raw, sync_pulse}, 0);
    @(negedge clk) rst = 1'b0;
    begin
      int act = 0;
      for (int i = 0; i < 20; i++) begin
        @(posedge clk); #1;
        if (ls_raw || sync_pulse || ls_out) act++;
      end
      chk(act == 0, "R1 count cleared", act, 0);
    end

    // R3/R9: fresh pulse after reset behaves normally
    @(negedge clk);
    dead_cycles = 8'd2;
    hs_high(9);
    measure(9, 2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule